// File: doc/BRIEF.md
# Exception Cause Detector and Vector Generator

This block watches three kinds of processor event and turns the most urgent one into an exception request. The request carries a vector address and a cause code. The three events are:

- **Store translation trap.** A store's data-side translation lookup either misses, or hits an entry whose modified flag has not been set yet.
- **Breakpoint match.** An armed breakpoint register matches the address of the instruction about to complete.
- **Management interrupt.** An asynchronous management-interrupt line is raised while external interrupts are enabled.

When a cause is taken, the block raises a one-cycle `excTaken` pulse. It then holds the cause code and vector address until the surrounding core acknowledges them. The translation lookaside buffer, the page-table walk and the pipeline flush all sit outside this block.

The vector address is a 20-bit offset under a 12-bit prefix. The prefix is chosen by `hiSel`: all zeros or all ones. The management line passes through a two-flop synchronizer and is treated as a level. The other two sources are sampled in the cycle they are presented.

Top module: `exc_cause_vec`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `excTaken` is 0, `cause` is 0 (none) and `vecAddr` is 0.
- R2: With `xlateOn`, `lookupValid` and `isStore` all 1 and `tlbHit` 0, the block takes a store translation trap. It reports cause code 2 and vector offset 0x01200 one clock edge later.
- R3: A store that hits (`tlbHit`=1) traps as in R2 when `chgBit` is 0. It does not trap when `chgBit` is 1. A lookup with `isStore`=0 never traps, and neither does a cycle with `lookupValid`=0.
- R4: When `xlateOn` is 0, no store translation trap is raised, whatever the other lookup inputs are.
- R5: Bit 0 is the most significant bit of a word. A breakpoint match is found when `bkptReg` bits 0–29 (`bkptReg[31:2]`) equal `nextPc[31:2]` and bit 30 (`bkptReg[1]`) is 1. It reports cause code 1 and offset 0x01300. Bit 31 (`bkptReg[0]`) and `nextPc[1:0]` have no effect.
- R6: A breakpoint register with its enable bit (`bkptReg[1]`) at 0 never matches.
- R7: A management interrupt is taken only while `intEnable` is 1 and the synchronized `mgmtIrq` is 1. It reports cause code 3 and offset 0x01400. If `mgmtIrq` rises before clock edge k with `intEnable` held at 1, `excTaken` first rises after edge k+2.
- R8: When several causes are present in one cycle, only one is reported. The order is: breakpoint match (1) first, then store translation trap (2), then management interrupt (3).
- R9: `vecAddr[31:20]` is 0x000 when `hiSel` was 0 at capture, and 0xFFF when it was 1. `vecAddr[19:0]` is the offset of the reported cause.
- R10: `excTaken` lasts exactly one cycle per taken cause. `cause` and `vecAddr` then hold until `ack` is 1 at a clock edge, which returns them to 0. No new cause is taken while one is held, including the cycle of the acknowledgement.
- R11: `vecAddr[19:0]` only ever takes the values 0, 0x01200, 0x01300 or 0x01400. No offset in the range 0x01500–0x02FFF is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xlateOn | input | 1 | Data address translation enabled |
| lookupValid | input | 1 | A data translation lookup result is presented this cycle |
| isStore | input | 1 | The presented access is a store |
| tlbHit | input | 1 | The lookup found a matching entry |
| chgBit | input | 1 | Modified flag of the matching entry |
| nextPc | input | 32 | Address of the next instruction to complete |
| bkptReg | input | 32 | Breakpoint register: [31:2] address, [1] enable, [0] ignored |
| intEnable | input | 1 | External interrupt enable |
| mgmtIrq | input | 1 | Asynchronous management-interrupt line |
| hiSel | input | 1 | Vector prefix select: 0 gives 0x000, 1 gives 0xFFF |
| ack | input | 1 | Acknowledge of the held cause |
| excTaken | output | 1 | One-cycle pulse when a cause is taken |
| cause | output | 2 | Held cause: 0 none, 1 breakpoint, 2 store trap, 3 management |
| vecAddr | output | 32 | Held vector address |

## Verification
The interesting collisions come from all three sources reaching the priority selector on the same clock edge. Two of them at once, the breakpoint match and the store trap, are the main pair to get right.

The management line is slow to arrive, so the bench parks it in the synchronizer with `intEnable` low. It then raises `intEnable` together with a matching breakpoint and a missing store lookup. This drives every one of the eight subsets of sources, under both prefixes, on a single edge.

Each outcome is judged against the priority order written into the bench. The bench also checks that the held cause survives later cycles in which the losing sources are still present.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int OFF_W = 20;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BKPT    = 2'd1,
    CAUSE_STMISS  = 2'd2,
    CAUSE_SYSMGMT = 2'd3
  } cause_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   capture;
    logic   clear;
    cause_e sel;
  } strobe_t;

  function automatic logic [OFF_W-1:0] causeOffset(input cause_e c);
    logic [OFF_W-1:0] off;
    case (c)
      CAUSE_STMISS:  off = 20'h01200;
      CAUSE_BKPT:    off = 20'h01300;
      CAUSE_SYSMGMT: off = 20'h01400;
      default:       off = '0;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlateOn,
  input  logic              lookupValid,
  input  logic              isStore,
  input  logic              tlbHit,
  input  logic              chgBit,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [ADDR_W-1:0] bkptReg,
  input  logic              intEnable,
  input  logic              mgmtIrq,
  input  logic              hiSel,
  input  strobe_t           stb,
  output logic              bkptHit,
  output logic              storeMiss,
  output logic              mgmtReq,
  output cause_e            causeQ,
  output logic [ADDR_W-1:0] vecQ
);

  localparam int PREFIX_W = ADDR_W - OFF_W;
  localparam int CMP_LO   = 2;           // word-aligned compare
  localparam int EN_BIT   = 1;           // big-endian bit 30

  // synchronizer chain for the asynchronous management line
  logic [SYNC_STAGES-1:0] syncQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else if (g == 0) syncQ[g] <= mgmtIrq;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  // raw cause conditions
  assign storeMiss = xlateOn & lookupValid & isStore & (~tlbHit | ~chgBit);
  assign bkptHit   = bkptReg[EN_BIT] &
                     (bkptReg[ADDR_W-1:CMP_LO] == nextPc[ADDR_W-1:CMP_LO]);
  assign mgmtReq   = intEnable & syncQ[SYNC_STAGES-1];

  logic unusedBits;
  assign unusedBits = ^{bkptReg[0], nextPc[CMP_LO-1:0]};

  logic [ADDR_W-1:0] vecNext;
  assign vecNext = {{PREFIX_W{hiSel}}, causeOffset(stb.sel)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= CAUSE_NONE;
      vecQ   <= '0;
    end else if (stb.clear) begin
      causeQ <= CAUSE_NONE;
      vecQ   <= '0;
    end else if (stb.capture) begin
      causeQ <= stb.sel;
      vecQ   <= vecNext;
    end
  end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bkptHit,
  input  logic    storeMiss,
  input  logic    mgmtReq,
  input  logic    ack,
  output strobe_t stb,
  output logic    excTaken
);

  logic   pending;
  cause_e winner;

  // fixed priority: breakpoint, store trap, management
  always_comb begin
    if (bkptHit)        winner = CAUSE_BKPT;
    else if (storeMiss) winner = CAUSE_STMISS;
    else if (mgmtReq)   winner = CAUSE_SYSMGMT;
    else                winner = CAUSE_NONE;
  end

  always_comb begin
    stb.sel     = winner;
    stb.capture = ~pending & (winner != CAUSE_NONE);
    stb.clear   = pending & ack;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      excTaken <= 1'b0;
    end else begin
      excTaken <= stb.capture;
      if (stb.capture)    pending <= 1'b1;
      else if (stb.clear) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/exc_cause_vec.sv
module exc_cause_vec
  import exc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlateOn,
  input  logic              lookupValid,
  input  logic              isStore,
  input  logic              tlbHit,
  input  logic              chgBit,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [ADDR_W-1:0] bkptReg,
  input  logic              intEnable,
  input  logic              mgmtIrq,
  input  logic              hiSel,
  input  logic              ack,
  output logic              excTaken,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] vecAddr
);

  strobe_t stb;
  logic    bkptHit;
  logic    storeMiss;
  logic    mgmtReq;
  cause_e  causeQ;

  exc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bkptHit  (bkptHit),
    .storeMiss(storeMiss),
    .mgmtReq  (mgmtReq),
    .ack      (ack),
    .stb      (stb),
    .excTaken (excTaken)
  );

  exc_datapath #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .xlateOn    (xlateOn),
    .lookupValid(lookupValid),
    .isStore    (isStore),
    .tlbHit     (tlbHit),
    .chgBit     (chgBit),
    .nextPc     (nextPc),
    .bkptReg    (bkptReg),
    .intEnable  (intEnable),
    .mgmtIrq    (mgmtIrq),
    .hiSel      (hiSel),
    .stb        (stb),
    .bkptHit    (bkptHit),
    .storeMiss  (storeMiss),
    .mgmtReq    (mgmtReq),
    .causeQ     (causeQ),
    .vecQ       (vecAddr)
  );

  assign cause = causeQ;

endmodule

// File: rtl/exc_cause_vec_chk.sv
module exc_cause_vec_chk (
  input logic        clk,
  input logic        rstN,
  input logic        xlateOn,
  input logic        hiSel,
  input logic        ack,
  input logic        excTaken,
  input logic [1:0]  cause,
  input logic [31:0] vecAddr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (cause == 2'd0 && !excTaken && vecAddr == 32'd0));

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> !excTaken);

  // R10
  pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> cause != 2'd0);

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cause != 2'd0 && !ack) |=> ($stable(cause) && $stable(vecAddr)));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cause != 2'd0 && ack) |=> (cause == 2'd0 && vecAddr == 32'd0));

  // R4
  xlate_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && cause == 2'd2) |-> $past(xlateOn));

  // R9
  prefix_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> vecAddr[31:20] == {12{$past(hiSel)}});

  // R11
  offset_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecAddr[19:0] == 20'h0 || vecAddr[19:0] == 20'h01200 ||
     vecAddr[19:0] == 20'h01300 || vecAddr[19:0] == 20'h01400));

endmodule

bind exc_cause_vec exc_cause_vec_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .xlateOn (xlateOn),
  .hiSel   (hiSel),
  .ack     (ack),
  .excTaken(excTaken),
  .cause   (cause),
  .vecAddr (vecAddr)
);

// File: tb/test_exc_cause_vec.sv
`timescale 1ns/1ps
module test_exc_cause_vec;

  logic        clk = 1'b0;
  logic        rstN;
  logic        xlateOn, lookupValid, isStore, tlbHit, chgBit;
  logic [31:0] nextPc, bkptReg;
  logic        intEnable, mgmtIrq, hiSel, ack;
  logic        excTaken;
  logic [1:0]  cause;
  logic [31:0] vecAddr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  exc_cause_vec i_exc_cause_vec (
    .clk(clk), .rstN(rstN), .xlateOn(xlateOn), .lookupValid(lookupValid),
    .isStore(isStore), .tlbHit(tlbHit), .chgBit(chgBit), .nextPc(nextPc),
    .bkptReg(bkptReg), .intEnable(intEnable), .mgmtIrq(mgmtIrq),
    .hiSel(hiSel), .ack(ack), .excTaken(excTaken), .cause(cause),
    .vecAddr(vecAddr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expVec(input int c, input logic hs);
    logic [19:0] off;
    case (c)
      1: off = 20'h01300;
      2: off = 20'h01200;
      3: off = 20'h01400;
      default: off = 20'h0;
    endcase
    return (c == 0) ? 32'h0 : {{12{hs}}, off};
  endfunction

  task automatic clearIn();
    xlateOn = 0; lookupValid = 0; isStore = 0; tlbHit = 0; chgBit = 0;
    nextPc = 32'h0; bkptReg = 32'h0; intEnable = 0; mgmtIrq = 0; ack = 0;
  endtask

  // called at the negedge after the edge that sampled the stimulus
  task automatic judge(input int expCause, input logic hs, input string req);
    chk({req, " taken"}, {31'd0, excTaken}, {31'd0, expCause != 0});
    chk({req, " cause"}, {30'd0, cause}, expCause);
    chk({req, " vec R9 R11"}, vecAddr, expVec(expCause, hs));
    clearIn();
    if (expCause != 0) begin
      tick();
      chk({req, " R10 pulse"}, {31'd0, excTaken}, 32'd0);
      chk({req, " R10 hold"}, {30'd0, cause}, expCause);
      ack = 1;
      tick();
      ack = 0;
      chk({req, " R10 ack"}, {30'd0, cause}, 32'd0);
      chk({req, " R10 ack vec"}, vecAddr, 32'd0);
    end
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    clearIn();
    hiSel = 0;
    rstN = 0;
    repeat (3) tick();
    // R1
    chk("R1 taken", {31'd0, excTaken}, 32'd0);
    chk("R1 cause", {30'd0, cause}, 32'd0);
    chk("R1 vec", vecAddr, 32'd0);
    rstN = 1;
    tick();
    chk("R1 after release", {30'd0, cause}, 32'd0);

    // R2 R3 R4: sweep every lookup input combination
    for (int i = 0; i < 64; i++) begin
      logic xo, lv, st, ht, cb, hs;
      int   e;
      {hs, xo, lv, st, ht, cb} = i[5:0];
      xlateOn = xo; lookupValid = lv; isStore = st; tlbHit = ht; chgBit = cb;
      hiSel = hs;
      e = (xo && lv && st && (!ht || !cb)) ? 2 : 0;
      tick();
      judge(e, hs, xo ? (ht ? "R3 store lookup" : "R2 store lookup")
                      : "R4 translation off");
    end

    // R5 R6: breakpoint address sweep
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      int          mode;
      a    = 32'h1357_9BDF * (i + 1) + 32'h0246_8ACE;
      mode = i % 4;
      hiSel = i[2];
      nextPc = a;
      case (mode)
        0: bkptReg = {a[31:2] , 1'b1, 1'b0};        // match
        1: bkptReg = {a[31:2] , 1'b1, ~a[0]};       // match, ignored bits vary
        2: bkptReg = {a[31:2] , 1'b0, 1'b1};        // disabled
        default: bkptReg = {a[31:2] ^ (30'd1 << (i % 30)), 1'b1, 1'b0};
      endcase
      if (mode == 1) nextPc[1:0] = ~a[1:0];
      tick();
      judge((mode < 2) ? 1 : 0, hiSel,
            (mode == 2) ? "R6 disabled bkpt" : "R5 bkpt compare");
    end

    // R7: synchronizer latency and enable gate
    hiSel = 0;
    intEnable = 1; mgmtIrq = 1;
    tick();
    chk("R7 latency edge1", {31'd0, excTaken}, 32'd0);
    tick();
    chk("R7 latency edge2", {31'd0, excTaken}, 32'd0);
    tick();
    chk("R7 latency edge3", {31'd0, excTaken}, 32'd1);
    chk("R7 cause", {30'd0, cause}, 32'd3);
    chk("R7 vec", vecAddr, 32'h0000_1400);
    mgmtIrq = 0;
    repeat (3) begin
      tick();
      chk("R10 no retake while held", {31'd0, excTaken}, 32'd0);
    end
    chk("R10 still held", {30'd0, cause}, 32'd3);
    ack = 1; tick(); ack = 0;
    tick();
    chk("R10 no retake after ack", {31'd0, excTaken}, 32'd0);
    clearIn();
    mgmtIrq = 1; intEnable = 0;
    repeat (4) tick();
    chk("R7 enable low gates", {31'd0, excTaken}, 32'd0);
    chk("R7 enable low cause", {30'd0, cause}, 32'd0);
    clearIn();
    repeat (3) tick();

    // R8 R9: every subset of simultaneous sources, both prefixes
    for (int i = 0; i < 16; i++) begin
      logic bk, ds, sm, hs;
      int   e;
      {hs, sm, ds, bk} = i[3:0];
      clearIn();
      mgmtIrq = sm;
      repeat (3) tick();
      hiSel = hs;
      intEnable = 1;
      nextPc = 32'hABCD_0120 + i * 4;
      bkptReg = bk ? {nextPc[31:2], 1'b1, 1'b0} : 32'h0;
      if (ds) begin xlateOn = 1; lookupValid = 1; isStore = 1; tlbHit = 0; end
      e = bk ? 1 : ds ? 2 : sm ? 3 : 0;
      tick();
      judge(e, hs, "R8 priority");
    end

    // R10: held cause is not replaced while sources stay present
    hiSel = 1;
    nextPc = 32'h0000_8000; bkptReg = 32'h0000_8002;
    tick();
    chk("R10 first take", {30'd0, cause}, 32'd1);
    xlateOn = 1; lookupValid = 1; isStore = 1; tlbHit = 0;
    tick();
    chk("R10 pulse over", {31'd0, excTaken}, 32'd0);
    chk("R10 held under load", {30'd0, cause}, 32'd1);
    chk("R10 held vec", vecAddr, 32'hFFF0_1300);
    ack = 1; tick(); ack = 0;
    chk("R10 ack cycle no take", {31'd0, excTaken}, 32'd0);
    chk("R10 ack cleared", {30'd0, cause}, 32'd0);
    tick();
    chk("R10 retake after ack", {30'd0, cause}, 32'd1);
    clearIn();
    ack = 1; tick(); ack = 0; tick();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule